// File: doc/BRIEF.md
# Memory Zero-Fill Sweep Engine

This block clears on-chip RAM regions after power-up or on request. A domain enable vector chooses which regions take part. A single-cycle start pulse makes the engine capture that vector and then walk the regions one after another. Each region is swept from address 0 up to its last word.

Every write stores an all-zero 64-bit data word together with the 8-bit check code that belongs to all-zero data, 0x0C. In the physical memory each half of the word sits in a 36-bit bank that holds 32 data bits and 4 check bits. The engine raises exactly one per-region write enable at a time. It reports busy while it sweeps and done once the sweep has finished. Start pulses that arrive while it is busy have no effect.

Top module: `memory_autoinit`

## Requirements
- R1: After reset, busy_o and done_o are 0 and all bits of wr_en_o are 0.
- R2: A start pulse (init_pulse_i high for one cycle) sampled while busy_o is 0 and dom_en_i is non-zero makes busy_o go to 1 in the next cycle. In that cycle wr_addr_o is 0 and wr_en_o has only the bit of the lowest-numbered enabled region set.
- R3: While busy, one word is written per clock cycle, and wr_addr_o counts up by one from 0 to DEPTH-1 inside each region.
- R4: Regions are swept in ascending index order. wr_en_o bit i is asserted only if bit i of the captured enable vector is 1, so disabled regions are never written.
- R5: wr_data_o is all zeros in every cycle in which any wr_en_o bit is set.
- R6: wr_ecc_o is 8'h0C in every cycle in which any wr_en_o bit is set.
- R7: A start pulse sampled while busy_o is 1 changes neither the order nor the number of writes.
- R8: done_o becomes 1 in the cycle after the last write and busy_o falls to 0 at the same time. done_o stays 1 until the next accepted start and reads 0 in the cycle after that start.
- R9: An accepted start with dom_en_i equal to zero produces no write. In that case done_o is 1 and busy_o is 0 in the next cycle.
- R10: dom_en_i is sampled only in the cycle where a start is accepted, so later changes have no effect on the sweep in progress.
- R11: At most one wr_en_o bit is set in any cycle, and none is set while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_pulse_i | input | 1 | Start request, one cycle wide |
| dom_en_i | input | NUM_DOM | Region enable vector, captured at an accepted start |
| wr_en_o | output | NUM_DOM | Per-region write enable, one-hot or zero |
| wr_addr_o | output | $clog2(DEPTH) | Word address inside the active region |
| wr_data_o | output | DATA_W | Write data, always zero |
| wr_ecc_o | output | ECC_W | Check code for the written word |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Last sweep complete |

## Verification
Two events are hard to reach from the ports. One is a start pulse that lands while the sweep is running. The other is a change on the enable vector in the middle of a sweep. Either one could corrupt the write order without any single output looking wrong. The stimulus drives random start pulses and random enable values on every cycle of a sweep, except the cycle just after the last write. It compares the full address and enable sequence against the sequence computed from the vector captured at start. Directed runs cover the all-zero mask, a single top region and the full mask.

// File: rtl/mi_pkg.sv
package mi_pkg;
   // Check code of an all-zero 64-bit word (two 36-bit banks, 4 check bits each)
   localparam logic [7:0] ZERO_WORD_ECC = 8'h0C;

   function automatic int unsigned count_set(input logic [31:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 32; i++) n += int'(v[i]);
      return n;
   endfunction
endpackage

// File: rtl/mi_dom_pick.sv
module mi_dom_pick #(
   parameter int NUM_DOM    = 4,
   parameter bit HIGH_FIRST = 1'b0
) (
   input  logic [NUM_DOM-1:0] pending_i,
   output logic [NUM_DOM-1:0] sel_o,
   output logic               any_o
);
   logic [NUM_DOM:0] seen;

   generate
      if (NUM_DOM < 1 || NUM_DOM > 32) begin : g_bad_num
         $error("mi_dom_pick: NUM_DOM out of range");
      end
      if (!HIGH_FIRST) begin : g_low
         assign seen[0] = 1'b0;
         for (genvar i = 0; i < NUM_DOM; i++) begin : g_chain
            assign sel_o[i]    = pending_i[i] & ~seen[i];
            assign seen[i+1]   = seen[i] | pending_i[i];
         end
      end else begin : g_high
         assign seen[NUM_DOM] = 1'b0;
         for (genvar i = NUM_DOM - 1; i >= 0; i--) begin : g_chain
            assign sel_o[i] = pending_i[i] & ~seen[i+1];
            assign seen[i]  = seen[i+1] | pending_i[i];
         end
      end
   endgenerate

   assign any_o = |pending_i;

   // R11
   always_comb begin
      one_sel_chk: assert ($onehot0(sel_o));
   end
endmodule

// File: rtl/mi_addr_ctr.sv
module mi_addr_ctr #(
   parameter int DEPTH  = 64,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          run_i,
   output logic [AW-1:0] addr_o,
   output logic          last_o
);
   localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mi_addr_ctr: DEPTH must be at least 2");
      end
   endgenerate

   assign last_o = run_i && (addr_o == LAST_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_o <= '0;
      else if (clr_i)   addr_o <= '0;
      else if (run_i)   addr_o <= last_o ? '0 : addr_o + 1'b1;
   end

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !last_o && !clr_i) |=> (addr_o == $past(addr_o) + 1'b1));
   // R3
   addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !clr_i) |=> (addr_o == '0));
endmodule

// File: rtl/mi_wr_drive.sv
module mi_wr_drive #(
   parameter int NUM_DOM = 4,
   parameter int AW      = 6,
   parameter int DATA_W  = 64,
   parameter int ECC_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DOM-1:0] sel_i,
   input  logic               busy_i,
   input  logic [AW-1:0]      addr_i,
   output logic [NUM_DOM-1:0] wr_en_o,
   output logic [AW-1:0]      wr_addr_o,
   output logic [DATA_W-1:0]  wr_data_o,
   output logic [ECC_W-1:0]   wr_ecc_o
);
   localparam int BANK_DATA_W = DATA_W / 2;
   localparam int BANK_ECC_W  = ECC_W / 2;

   logic [NUM_DOM-1:0] en_c;

   generate
      if (DATA_W != 64 || ECC_W != 8) begin : g_bad_word
         $error("mi_wr_drive: word must be 64 data bits with 8 check bits");
      end
      if (BANK_DATA_W + BANK_ECC_W != 36) begin : g_bad_bank
         $error("mi_wr_drive: each bank must be 36 bits wide");
      end
   endgenerate

   assign en_c = busy_i ? sel_i : '0;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_en_o   <= '0;
               wr_addr_o <= '0;
            end else begin
               wr_en_o   <= en_c;
               wr_addr_o <= addr_i;
            end
         end
      end else begin : g_comb
         assign wr_en_o   = en_c;
         assign wr_addr_o = addr_i;
      end
   endgenerate

   assign wr_data_o = '0;
   assign wr_ecc_o  = mi_pkg::ZERO_WORD_ECC;

   // R5
   zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_en_o) |-> (wr_data_o == '0));
   // R6
   zero_ecc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_en_o) |-> (wr_ecc_o == 8'h0C));
endmodule

// File: rtl/memory_autoinit.sv
module memory_autoinit #(
   parameter int NUM_DOM    = 4,
   parameter int DEPTH      = 64,
   parameter int DATA_W     = 64,
   parameter int ECC_W      = 8,
   parameter bit HIGH_FIRST = 1'b0,
   parameter bit OUT_REG    = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       init_pulse_i,
   input  logic [NUM_DOM-1:0]         dom_en_i,
   output logic [NUM_DOM-1:0]         wr_en_o,
   output logic [$clog2(DEPTH)-1:0]   wr_addr_o,
   output logic [DATA_W-1:0]          wr_data_o,
   output logic [ECC_W-1:0]           wr_ecc_o,
   output logic                       busy_o,
   output logic                       done_o
);
   localparam int AW = $clog2(DEPTH);

   logic [NUM_DOM-1:0] pending_q, sel, remain;
   logic               any_pend, accept, last_word;
   logic [AW-1:0]      addr;

   mi_dom_pick #(.NUM_DOM(NUM_DOM), .HIGH_FIRST(HIGH_FIRST)) pick_i (
      .pending_i(pending_q), .sel_o(sel), .any_o(any_pend));

   assign busy_o = any_pend;
   assign accept = init_pulse_i & ~busy_o;
   assign remain = pending_q & ~sel;

   mi_addr_ctr #(.DEPTH(DEPTH)) ctr_i (
      .clk(clk), .rst_n(rst_n), .clr_i(accept), .run_i(busy_o),
      .addr_o(addr), .last_o(last_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= '0;
         done_o    <= 1'b0;
      end else if (accept) begin
         pending_q <= dom_en_i;
         done_o    <= (dom_en_i == '0);
      end else if (last_word) begin
         pending_q <= remain;
         if (remain == '0) done_o <= 1'b1;
      end
   end

   mi_wr_drive #(.NUM_DOM(NUM_DOM), .AW(AW), .DATA_W(DATA_W), .ECC_W(ECC_W),
                 .OUT_REG(OUT_REG)) drv_i (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .busy_i(busy_o), .addr_i(addr),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .wr_ecc_o(wr_ecc_o));

   // R8
   done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o));
   // R7
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && init_pulse_i && !last_word) |=> (pending_q == $past(pending_q)));
   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !accept) |=> done_o);
   // R9
   empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dom_en_i == '0) |=> (done_o && !busy_o));
   // R4
   pending_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !accept) |=> ((pending_q & ~$past(pending_q)) == '0));
endmodule

// File: tb/memory_autoinit_tb_top.sv
module memory_autoinit_tb_top;
   localparam int ND = 4;
   localparam int DP = 64;
   localparam int AW = $clog2(DP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pulse = 1'b0;
   logic [ND-1:0] den = '0;
   logic [ND-1:0] wr_en;
   logic [AW-1:0] wr_addr;
   logic [63:0]   wr_data;
   logic [7:0]    wr_ecc;
   logic          busy, done;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   memory_autoinit #(.NUM_DOM(ND), .DEPTH(DP)) dut_i (
      .clk(clk), .rst_n(rst_n), .init_pulse_i(pulse), .dom_en_i(den),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .wr_ecc_o(wr_ecc), .busy_o(busy), .done_o(done));

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   function automatic logic [ND-1:0] bit_of(input int d);
      return ND'(1) << d;
   endfunction

   task automatic check_idle_done(input string req);
      chk(busy == 1'b0, req, "busy after sweep", 64'(busy), 64'd0);
      chk(done == 1'b1, req, "done after sweep", 64'(done), 64'd1);
      chk(wr_en == '0, "R11", "wr_en while idle", 64'(wr_en), 64'd0);
   endtask

   task automatic sweep(input logic [ND-1:0] m, input bit noise);
      @(negedge clk);
      den   = m;
      pulse = 1'b1;
      @(negedge clk);
      pulse = 1'b0;
      chk(done == 1'b0 || m == '0, "R8", "done cleared by start", 64'(done), 64'd0);
      for (int d = 0; d < ND; d++) begin
         if (m[d]) begin
            for (int a = 0; a < DP; a++) begin
               chk(busy == 1'b1, (a == 0) ? "R2" : "R3", "busy during sweep",
                   64'(busy), 64'd1);
               chk(wr_en == bit_of(d), "R4", "region enable", 64'(wr_en), 64'(bit_of(d)));
               chk(wr_addr == AW'(a), "R3", "address", 64'(wr_addr), 64'(a));
               chk(wr_data == '0, "R5", "data", wr_data, 64'd0);
               chk(wr_ecc == 8'h0C, "R6", "ecc", 64'(wr_ecc), 64'h0C);
               if (noise) begin
                  // R7 start during busy, R10 enable change during sweep
                  pulse = 1'($urandom % 2);
                  den   = ND'($urandom);
               end
               @(negedge clk);
            end
         end
      end
      pulse = 1'b0;
      check_idle_done(m == '0 ? "R9" : "R8");
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(done == 1'b1, "R8", "done holds while idle", 64'(done), 64'd1);
         chk(wr_en == '0, "R11", "no write while idle", 64'(wr_en), 64'd0);
      end
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1
      chk(busy == 1'b0, "R1", "busy in reset", 64'(busy), 64'd0);
      chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'd0);
      chk(wr_en == '0, "R1", "wr_en in reset", 64'(wr_en), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && wr_en == '0, "R1", "state after reset",
          {61'd0, busy, done, |wr_en}, 64'd0);

      sweep(4'b1111, 1'b0);
      sweep(4'b0000, 1'b0);     // R9
      sweep(4'b1000, 1'b1);
      sweep(4'b0101, 1'b1);     // R4 skip disabled regions
      for (int r = 0; r < 8; r++) begin
         sweep(ND'($urandom), 1'b1);
      end
      finish_run();
   end
endmodule